// File: doc/BRIEF.md
# Level-2 Interrupt and Trap Sequencer

This block decides when the processor performs a level-2 context switch, and of which kind. Two causes compete for it. The first is the composite level-2 error request, a level signal built from the memory, mapping, bus-timeout, overflow and privilege error flags. This ordinary interrupt is gated by the current interrupt mask and by the instruction-boundary strobe. The second is the undefined-opcode strobe from instruction decode. It raises a trap that ignores the mask, wins over any pending interrupt, and leaves the mask as it was.

When either cause is taken, the block raises a one-cycle take pulse together with a flag that gives the kind. For an ordinary interrupt it also writes the new mask value. It then presents the two vector fetch addresses one after the other: first the new workspace pointer location, then the new program counter location. After that it returns to idle. An undefined-opcode strobe that arrives while a sequence is running is held and served as soon as the block is idle again. The register save, the higher interrupt levels and opcode decode are handled by neighbouring logic.

Top module: `l2_trap_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, take_o, vec_valid_o and mask_we_o are low.
- R2: An undefined-opcode strobe seen while idle causes take_o high with take_trap_o=1 in the next cycle, whatever the mask value (including 0) and whatever the boundary strobe.
- R3: An ordinary level-2 request is taken only when mask_i is 2 or greater; with mask_i at 0 or 1 no take occurs.
- R4: An ordinary level-2 request is taken only in a cycle where instr_bnd_i is high; no take occurs while instr_bnd_i is low.
- R5: In the cycle after a take, vec_valid_o=1 with vec_addr_o=0x0008; in the cycle after that, vec_valid_o=1 with vec_addr_o=0x000A; vec_valid_o is low otherwise.
- R6: When an ordinary interrupt is taken (take_trap_o=0), mask_we_o is high in the take cycle with mask_o=1.
- R7: When a trap is taken (take_trap_o=1), mask_we_o stays low.
- R8: If the trap and a qualified ordinary request are present in the same idle cycle, the trap is taken first. The ordinary request stays pending and is taken two cycles after the trap's 0x000A fetch cycle.
- R9: An undefined-opcode strobe that arrives during a running sequence is held. A trap take follows two cycles after that sequence's 0x000A fetch cycle.
- R10: take_trap_o is 1 for a trap take and 0 for an ordinary interrupt take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l2_req_i | input | 1 | Composite level-2 error request (level) |
| undef_op_i | input | 1 | Undefined-opcode decode strobe |
| instr_bnd_i | input | 1 | Instruction-boundary strobe |
| mask_i | input | 4 | Current interrupt mask |
| take_o | output | 1 | One-cycle context-switch take pulse |
| take_trap_o | output | 1 | Kind of take: 1 trap, 0 interrupt |
| vec_valid_o | output | 1 | Vector fetch address valid |
| vec_addr_o | output | 16 | Vector fetch word address |
| mask_we_o | output | 1 | Interrupt mask write enable |
| mask_o | output | 4 | New interrupt mask value |

## Verification
The ordinary request is held with mask values 0 and 1 and boundary high, then with mask 2 and boundary low. Any take in these windows would show a broken mask gate or a broken boundary gate. The request is then allowed through at mask 2 and at mask 15, so the comparison can be confirmed at both ends of the allowed range. The trap is raised with a zero mask and no boundary, which separates its path from the gated one. Further patterns make it coincide with a qualified interrupt, and raise it again in the middle of a running sequence. These two show whether arbitration picks the trap first and whether a late strobe is kept or dropped. The bench models the mask register as a loop fed by mask_we_o, so a wrong mask write shows up as repeated takes.

// File: rtl/l2_trap_pkg.sv
package l2_trap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAKE = 2'd1,
    ST_WP   = 2'd2,
    ST_PC   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/l2_trap_arb.sv
module l2_trap_arb #(
  parameter int MASK_W   = 4,
  parameter int L2_LEVEL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              l2_req_i,
  input  logic              undef_op_i,
  input  logic              instr_bnd_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              go_o,
  output logic              go_trap_o
);
  localparam logic [MASK_W-1:0] LvlMin = MASK_W'(L2_LEVEL);

  logic trap_pend_q;
  logic trap_hit, int_hit;

  assign trap_hit  = undef_op_i | trap_pend_q;
  assign int_hit   = l2_req_i & instr_bnd_i & (mask_i >= LvlMin);
  // trap beats the maskable request
  assign go_trap_o = idle_i & trap_hit;
  assign go_o      = idle_i & (trap_hit | int_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_pend_q <= 1'b0;
    else         trap_pend_q <= trap_hit & ~idle_i;
  end

  // R9: a strobe seen while busy must be held
  a_r9_hold_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_op_i && !idle_i) |=> trap_pend_q);
  // R3 / R4: the gated path never fires without its qualifiers
  a_r3_int_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !go_trap_o) |-> (mask_i >= LvlMin && instr_bnd_i && l2_req_i));
endmodule

// File: rtl/l2_trap_fsm.sv
module l2_trap_fsm
  import l2_trap_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_i,
  input  logic    go_trap_i,
  output seq_st_e state_o,
  output logic    trap_o,
  output logic    idle_o
);
  seq_st_e st_q, st_d;
  logic    trap_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_i) st_d = ST_TAKE;
      ST_TAKE: st_d = ST_WP;
      ST_WP:   st_d = ST_PC;
      ST_PC:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      trap_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && go_i) trap_q <= go_trap_i;
    end
  end

  assign state_o = st_q;
  assign trap_o  = trap_q;
  assign idle_o  = (st_q == ST_IDLE);

  a_r5_seq_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAKE) |=> (st_q == ST_WP) ##1 (st_q == ST_PC) ##1 (st_q == ST_IDLE));
endmodule

// File: rtl/l2_trap_vec.sv
module l2_trap_vec
  import l2_trap_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              MASK_W   = 4,
  parameter logic [ADDR_W-1:0] WP_VEC = 16'h0008,
  parameter logic [ADDR_W-1:0] PC_VEC = 16'h000A,
  parameter int              NEW_MASK = 1
) (
  input  seq_st_e           state_i,
  input  logic              trap_i,
  output logic              take_o,
  output logic              take_trap_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              mask_we_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam logic [MASK_W-1:0] MaskLoad = MASK_W'(NEW_MASK);

  assign take_o      = (state_i == ST_TAKE);
  assign take_trap_o = take_o & trap_i;
  // trap leaves the mask untouched
  assign mask_we_o   = take_o & ~trap_i;
  assign mask_o      = mask_we_o ? MaskLoad : '0;

  always_comb begin
    vec_valid_o = 1'b0;
    vec_addr_o  = '0;
    if (state_i == ST_WP) begin
      vec_valid_o = 1'b1;
      vec_addr_o  = WP_VEC;
    end else if (state_i == ST_PC) begin
      vec_valid_o = 1'b1;
      vec_addr_o  = PC_VEC;
    end
  end

  always_comb begin
    if (take_trap_o) a_r7_no_mask_write: assert (!mask_we_o);
  end
endmodule

// File: rtl/l2_trap_seq.sv
module l2_trap_seq
  import l2_trap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MASK_W   = 4,
  parameter int L2_LEVEL = 2,
  parameter int NEW_MASK = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l2_req_i,
  input  logic              undef_op_i,
  input  logic              instr_bnd_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              take_o,
  output logic              take_trap_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              mask_we_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] WpVec = ADDR_W'(16'h0008);
  localparam logic [ADDR_W-1:0] PcVec = ADDR_W'(16'h000A);

  logic    idle, go, go_trap, trap_q;
  seq_st_e state;

  l2_trap_arb #(.MASK_W(MASK_W), .L2_LEVEL(L2_LEVEL)) u_arb (
    .clk_i, .rst_ni,
    .idle_i(idle), .l2_req_i, .undef_op_i, .instr_bnd_i, .mask_i,
    .go_o(go), .go_trap_o(go_trap)
  );

  l2_trap_fsm u_fsm (
    .clk_i, .rst_ni,
    .go_i(go), .go_trap_i(go_trap),
    .state_o(state), .trap_o(trap_q), .idle_o(idle)
  );

  l2_trap_vec #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W),
    .WP_VEC(WpVec), .PC_VEC(PcVec), .NEW_MASK(NEW_MASK)
  ) u_vec (
    .state_i(state), .trap_i(trap_q),
    .take_o, .take_trap_o, .vec_valid_o, .vec_addr_o, .mask_we_o, .mask_o
  );

  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!take_o && !vec_valid_o && !mask_we_o);
  end

  a_r2_trap_ungated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_op_i && idle) |=> (take_o && take_trap_o));
  a_r4_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !instr_bnd_i && !undef_op_i && !go_trap) |=> !take_o);
  a_r6_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_trap_o) |-> (mask_we_o && mask_o == MASK_W'(NEW_MASK)));
  a_r5_wp_then_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_addr_o == WpVec) |=> (vec_valid_o && vec_addr_o == PcVec));
  a_r8_trap_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && undef_op_i && l2_req_i && instr_bnd_i) |=> take_trap_o);
endmodule

// File: tb/l2_trap_seq_bench.sv
`timescale 1ns/1ps
module l2_trap_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        l2_req_i = 1'b0, undef_op_i = 1'b0, instr_bnd_i = 1'b0;
  logic [3:0]  mask_r = 4'd0;
  logic        take_o, take_trap_o, vec_valid_o, mask_we_o;
  logic [15:0] vec_addr_o;
  logic [3:0]  mask_o;

  always #2.5 clk_i = ~clk_i;

  l2_trap_seq u_l2_trap_seq (
    .clk_i, .rst_ni, .l2_req_i, .undef_op_i, .instr_bnd_i, .mask_i(mask_r),
    .take_o, .take_trap_o, .vec_valid_o, .vec_addr_o, .mask_we_o, .mask_o
  );

  // mask register model fed by the block's write port
  always @(posedge clk_i) if (rst_ni && mask_we_o) mask_r <= mask_o;

  typedef struct {
    string       req;
    int          delta;
    logic        take;
    logic        trap;
    logic        mwe;
    logic [3:0]  mval;
    logic        valid;
    logic [15:0] addr;
  } evt_t;

  evt_t exp_q[$];
  int   n_vec = 0, n_bad = 0;
  int   cyc = 0, last_cyc = 0;
  bit   done = 0;

  task automatic push_take(string req, int delta, logic trap);
    evt_t e;
    e.req = req; e.delta = delta; e.take = 1; e.trap = trap;
    e.mwe = !trap; e.mval = trap ? 4'd0 : 4'd1; e.valid = 0; e.addr = '0;
    exp_q.push_back(e);
  endtask

  task automatic push_vecs(string req);
    evt_t e;
    e.req = req; e.delta = 1; e.take = 0; e.trap = 0; e.mwe = 0; e.mval = 0;
    e.valid = 1; e.addr = 16'h0008; exp_q.push_back(e);
    e.addr = 16'h000A; exp_q.push_back(e);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cyc++;
      if (take_o || vec_valid_o) begin
        evt_t e;
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected event: take=%0b trap=%0b valid=%0b addr=%h (expected none, R3/R4)",
                   take_o, take_trap_o, vec_valid_o, vec_addr_o);
        end else begin
          e = exp_q.pop_front();
          if (take_o !== e.take || take_trap_o !== e.trap || mask_we_o !== e.mwe ||
              (e.mwe && mask_o !== e.mval) || vec_valid_o !== e.valid ||
              vec_addr_o !== e.addr || (e.delta >= 0 && cyc - last_cyc != e.delta)) begin
            n_bad++;
            $display("FAIL %s: got take=%0b trap=%0b mwe=%0b mask=%0d valid=%0b addr=%h gap=%0d, exp take=%0b trap=%0b mwe=%0b mask=%0d valid=%0b addr=%h gap=%0d",
                     e.req, take_o, take_trap_o, mask_we_o, mask_o, vec_valid_o, vec_addr_o,
                     cyc - last_cyc, e.take, e.trap, e.mwe, e.mval, e.valid, e.addr, e.delta);
          end
        end
        last_cyc = cyc;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle_cycles(2);
    // R1: quiet in reset
    n_vec++;
    if (take_o || vec_valid_o || mask_we_o) begin
      n_bad++;
      $display("FAIL R1 in reset: take=%0b valid=%0b mwe=%0b exp 0 0 0", take_o, vec_valid_o, mask_we_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_vec++;
    if (take_o || vec_valid_o || mask_we_o) begin
      n_bad++;
      $display("FAIL R1 after reset: take=%0b valid=%0b mwe=%0b exp 0 0 0", take_o, vec_valid_o, mask_we_o);
    end

    // R2 R7 R10 R5: trap with mask 0, no boundary
    undef_op_i = 1;
    push_take("R2/R7/R10 trap ungated", -1, 1'b1);
    push_vecs("R5 vector pair after trap");
    @(negedge clk_i); undef_op_i = 0;
    idle_cycles(6);

    // R3: mask 1 then 0 must block the request
    l2_req_i = 1; instr_bnd_i = 1; mask_r = 4'd1;
    idle_cycles(8);
    mask_r = 4'd0;
    idle_cycles(8);
    // R4: mask ok but no boundary
    instr_bnd_i = 0; mask_r = 4'd2;
    idle_cycles(8);
    // R3 R6: boundary pulse at mask 2
    instr_bnd_i = 1;
    push_take("R3/R6/R10 interrupt at mask 2", -1, 1'b0);
    push_vecs("R5 vector pair after interrupt");
    @(negedge clk_i); instr_bnd_i = 0;
    idle_cycles(6);
    l2_req_i = 0;
    // R3 R6: mask 15, request and boundary held; mask load stops repeats
    mask_r = 4'd15; l2_req_i = 1; instr_bnd_i = 1;
    push_take("R3/R6 interrupt at mask 15", -1, 1'b0);
    push_vecs("R5 vector pair at mask 15");
    idle_cycles(12);
    l2_req_i = 0; instr_bnd_i = 0;
    idle_cycles(2);

    // R8: trap and qualified request together
    mask_r = 4'd2; l2_req_i = 1; instr_bnd_i = 1; undef_op_i = 1;
    push_take("R8 trap first", -1, 1'b1);
    push_vecs("R5 vectors for trap in R8");
    push_take("R8 interrupt after trap", 2, 1'b0);
    push_vecs("R5 vectors for interrupt in R8");
    @(negedge clk_i); undef_op_i = 0;
    idle_cycles(14);
    l2_req_i = 0; instr_bnd_i = 0;
    idle_cycles(2);

    // R9: second strobe during running sequence
    undef_op_i = 1;
    push_take("R9 first trap", -1, 1'b1);
    push_vecs("R5 vectors for first trap");
    push_take("R9 held trap", 2, 1'b1);
    push_vecs("R5 vectors for held trap");
    @(negedge clk_i); undef_op_i = 0;
    @(negedge clk_i); undef_op_i = 1;
    @(negedge clk_i); undef_op_i = 0;
    idle_cycles(14);

    done = 1;
    while (exp_q.size() != 0) begin
      evt_t e;
      e = exp_q.pop_front();
      n_vec++; n_bad++;
      $display("FAIL %s: event missing (got none, exp take=%0b addr=%h)", e.req, e.take, e.addr);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule